// File: doc/BRIEF.md
# Tree Node Order Lister

This block walks a binary tree held in an external topology memory and writes the addresses of the internal nodes it visits, one per clock, into a node order memory. The walk starts at a root address given with a start pulse. That root can be the root of the whole tree or of any subtree. The order produced is a pre-order: each node, then its left subtree, then its right subtree. A later engine that reads the list backwards gets a bottom-up order in which every node comes after its children.

Each topology entry describes one internal node. It holds a left child reference, a right child reference and a parent reference. A reference carries a leaf flag above the address. Leaves are terminal and are never listed. To hold a pending right branch, the walker keeps an internal LIFO whose depth equals the largest number of internal nodes. A read of the topology memory returns its data one cycle after the address is given. The walker always puts out the next address in the same cycle that it consumes the current entry. When the walk ends, the block gives a done pulse and the number of nodes it listed.

Top module: `tree_order_lister`

## Requirements
- R1: After reset `busy_o`, `done_o`, `ord_we_o` and `topo_rd_o` are low and `count_o` is zero.
- R2: When idle, `start_i` high in a cycle drives `topo_rd_o` high with `topo_addr_o` equal to `root_i` in that same cycle. The first listed node, in the next cycle, is that root.
- R3: A topology entry is `{parent, right, left}`, each `ADDR_W+1` bits wide with left in the lowest bits. In a reference, the top bit is 1 for a leaf and 0 for an internal node. The parent field has no effect on the walk (all ones marks the tree root).
- R4: While busy, every cycle writes exactly one node. `ord_we_o` is high, `ord_data_o` is the node address and `ord_addr_o` counts up from 0 with no gaps.
- R5: When both children are internal, the right child is saved on the stack and the left child is listed next.
- R6: When the left child is internal and the right is a leaf, the left child is listed next.
- R7: When the left child is a leaf and the right is internal, the right child is listed next.
- R8: When both children are leaves, the most recently saved node is listed next. If the stack is empty, the walk ends.
- R9: `done_o` is a one-cycle pulse in the cycle after the last write. `busy_o` is low in that cycle. `count_o` equals the number of nodes listed and holds until the next start.
- R10: `start_i` while busy has no effect on the order, the count or the timing of the current walk.
- R11: Trees of up to `MAX_NODES` internal nodes are listed completely, so a walk of n nodes takes exactly n write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk at `root_i` (ignored while busy) |
| root_i | input | ADDR_W | Address of the starting internal node |
| topo_rd_o | output | 1 | Topology memory read enable |
| topo_addr_o | output | ADDR_W | Topology memory read address |
| topo_data_i | input | 3*(ADDR_W+1) | Entry read, valid one cycle after the address |
| ord_we_o | output | 1 | Node order memory write enable |
| ord_addr_o | output | $clog2(MAX_NODES) | Node order memory write address |
| ord_data_o | output | ADDR_W | Listed node address |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| count_o | output | $clog2(MAX_NODES+1) | Nodes listed in the last walk |

## Verification
The walker is tested on several tree shapes:
- A balanced tree, which pushes a right branch and pops it back.
- A left comb and a right comb, each of which drives a single child-type pairing on every step.
- A single-node root, which ends on an empty stack at once.
- A mixed subtree that starts at a non-zero root.
- A complete tree with the maximum number of nodes, which fills the order memory and deepens the stack.

A behavioural pre-order model gives the expected address in every write cycle. A mix-up between left and right, or a pop of the wrong entry, then shows up as a wrong address. The balanced tree is listed twice with different parent fields. A second start in the middle of a walk must leave the sequence and the count unchanged.

// File: rtl/tol_pkg.sv
package tol_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_WALK
    } tol_state_e;

    typedef enum logic [2:0] {
        ACT_SAVE_RIGHT_GO_LEFT,
        ACT_GO_LEFT,
        ACT_GO_RIGHT,
        ACT_RESUME,
        ACT_FINISH
    } tol_act_e;

endpackage

// File: rtl/tol_step.sv
module tol_step
    import tol_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W:0]   left_ref_i,
    input  logic [ADDR_W:0]   right_ref_i,
    input  logic              stk_empty_i,
    input  logic [ADDR_W-1:0] stk_top_i,
    output tol_act_e          act_o,
    output logic [ADDR_W-1:0] next_addr_o,
    output logic [ADDR_W-1:0] save_addr_o
);

    logic left_leaf;
    logic right_leaf;

    assign left_leaf   = left_ref_i[ADDR_W];
    assign right_leaf  = right_ref_i[ADDR_W];
    assign save_addr_o = right_ref_i[ADDR_W-1:0];

    always_comb begin
        act_o       = ACT_FINISH;
        next_addr_o = '0;
        unique case ({left_leaf, right_leaf})
            2'b00: begin
                act_o       = ACT_SAVE_RIGHT_GO_LEFT;
                next_addr_o = left_ref_i[ADDR_W-1:0];
            end
            2'b01: begin
                act_o       = ACT_GO_LEFT;
                next_addr_o = left_ref_i[ADDR_W-1:0];
            end
            2'b10: begin
                act_o       = ACT_GO_RIGHT;
                next_addr_o = right_ref_i[ADDR_W-1:0];
            end
            default: begin
                if (stk_empty_i) begin
                    act_o = ACT_FINISH;
                end else begin
                    act_o       = ACT_RESUME;
                    next_addr_o = stk_top_i;
                end
            end
        endcase
    end

endmodule

// File: rtl/tol_stack.sv
module tol_stack #(
    parameter int DEPTH = 31,
    parameter int W     = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    output logic [W-1:0] top_o,
    output logic         empty_o,
    output logic         full_o
);

    localparam int PW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0]             sp;
        logic [DEPTH-1:0][W-1:0]   mem;
    } stk_regs_t;

    stk_regs_t stk_d, stk_q;
    logic [PW-1:0] top_idx;

    assign empty_o = (stk_q.sp == '0);
    assign full_o  = (stk_q.sp == PW'(DEPTH));
    assign top_idx = stk_q.sp - PW'(1);

    always_comb begin
        top_o = '0;
        if (!empty_o) begin
            top_o = stk_q.mem[top_idx];
        end
    end

    always_comb begin
        stk_d = stk_q;
        if (push_i && !full_o) begin
            stk_d.mem[stk_q.sp] = push_data_i;
            stk_d.sp            = stk_q.sp + PW'(1);
        end else if (pop_i && !empty_o) begin
            stk_d.sp = top_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o); // R11
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o); // R8
    AST_RESUME_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> (stk_q.sp == $past(stk_q.sp) - PW'(1))); // R8

endmodule

// File: rtl/tree_order_lister.sv
module tree_order_lister
    import tol_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int MAX_NODES = 31
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start_i,
    input  logic [ADDR_W-1:0]                    root_i,
    output logic                                 topo_rd_o,
    output logic [ADDR_W-1:0]                    topo_addr_o,
    input  logic [3*(ADDR_W+1)-1:0]              topo_data_i,
    output logic                                 ord_we_o,
    output logic [$clog2(MAX_NODES)-1:0]         ord_addr_o,
    output logic [ADDR_W-1:0]                    ord_data_o,
    output logic                                 busy_o,
    output logic                                 done_o,
    output logic [$clog2(MAX_NODES+1)-1:0]       count_o
);

    localparam int REF_W = ADDR_W + 1;
    localparam int OA_W  = $clog2(MAX_NODES);
    localparam int CNT_W = $clog2(MAX_NODES + 1);

    typedef struct packed {
        tol_state_e          state;
        logic [ADDR_W-1:0]   cur;
        logic [CNT_W-1:0]    cnt;
        logic                done;
    } lst_regs_t;

    lst_regs_t lst_d, lst_q;

    logic [REF_W-1:0]  left_ref;
    logic [REF_W-1:0]  right_ref;
    tol_act_e          act;
    logic [ADDR_W-1:0] next_addr;
    logic [ADDR_W-1:0] save_addr;
    logic              stk_push;
    logic              stk_pop;
    logic [ADDR_W-1:0] stk_top;
    logic              stk_empty;
    logic              stk_full;

    assign left_ref  = topo_data_i[REF_W-1:0];
    assign right_ref = topo_data_i[2*REF_W-1:REF_W];

    tol_step #(
        .ADDR_W (ADDR_W)
    ) step_i (
        .left_ref_i  (left_ref),
        .right_ref_i (right_ref),
        .stk_empty_i (stk_empty),
        .stk_top_i   (stk_top),
        .act_o       (act),
        .next_addr_o (next_addr),
        .save_addr_o (save_addr)
    );

    tol_stack #(
        .DEPTH (MAX_NODES),
        .W     (ADDR_W)
    ) stack_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (stk_push),
        .push_data_i (save_addr),
        .pop_i       (stk_pop),
        .top_o       (stk_top),
        .empty_o     (stk_empty),
        .full_o      (stk_full)
    );

    always_comb begin
        lst_d       = lst_q;
        lst_d.done  = 1'b0;
        topo_rd_o   = 1'b0;
        topo_addr_o = '0;
        ord_we_o    = 1'b0;
        ord_addr_o  = lst_q.cnt[OA_W-1:0];
        ord_data_o  = lst_q.cur;
        stk_push    = 1'b0;
        stk_pop     = 1'b0;
        unique case (lst_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    topo_rd_o   = 1'b1;
                    topo_addr_o = root_i;
                    lst_d.cur   = root_i;
                    lst_d.cnt   = '0;
                    lst_d.state = ST_WALK;
                end
            end
            default: begin
                ord_we_o  = 1'b1;
                lst_d.cnt = lst_q.cnt + CNT_W'(1);
                if (act == ACT_FINISH) begin
                    lst_d.state = ST_IDLE;
                    lst_d.done  = 1'b1;
                end else begin
                    topo_rd_o   = 1'b1;
                    topo_addr_o = next_addr;
                    lst_d.cur   = next_addr;
                    stk_push    = (act == ACT_SAVE_RIGHT_GO_LEFT);
                    stk_pop     = (act == ACT_RESUME);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lst_q <= '{state: ST_IDLE, cur: '0, cnt: '0, done: 1'b0};
        end else begin
            lst_q <= lst_d;
        end
    end

    assign busy_o  = (lst_q.state == ST_WALK);
    assign done_o  = lst_q.done;
    assign count_o = lst_q.cnt;

    AST_START_LISTS_ROOT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (ord_we_o && ord_data_o == $past(root_i))); // R2
    AST_ORDER_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ord_we_o && $past(ord_we_o)) |-> (ord_addr_o == $past(ord_addr_o) + OA_W'(1))); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(ord_we_o) && !busy_o)); // R9
    AST_EMPTY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> stk_empty); // R8
    AST_STACK_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !(stk_full && stk_push)); // R11

endmodule

// File: tb/tree_order_lister_tb_top.sv
module tree_order_lister_tb_top;

    localparam int ADDR_W    = 5;
    localparam int MAX_NODES = 31;
    localparam int REF_W     = ADDR_W + 1;
    localparam int ENTRY_W   = 3 * REF_W;
    localparam int OA_W      = $clog2(MAX_NODES);
    localparam int CNT_W     = $clog2(MAX_NODES + 1);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start_i = 1'b0;
    logic [ADDR_W-1:0]   root_i = '0;
    logic                topo_rd_o;
    logic [ADDR_W-1:0]   topo_addr_o;
    logic [ENTRY_W-1:0]  topo_data_i = '0;
    logic                ord_we_o;
    logic [OA_W-1:0]     ord_addr_o;
    logic [ADDR_W-1:0]   ord_data_o;
    logic                busy_o;
    logic                done_o;
    logic [CNT_W-1:0]    count_o;

    logic [ENTRY_W-1:0]  mem [32];
    int                  exp_q[$];
    int                  n_checks = 0;
    int                  n_fails = 0;

    always #4 clk = ~clk;

    tree_order_lister #(
        .ADDR_W    (ADDR_W),
        .MAX_NODES (MAX_NODES)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .root_i      (root_i),
        .topo_rd_o   (topo_rd_o),
        .topo_addr_o (topo_addr_o),
        .topo_data_i (topo_data_i),
        .ord_we_o    (ord_we_o),
        .ord_addr_o  (ord_addr_o),
        .ord_data_o  (ord_data_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .count_o     (count_o)
    );

    always @(posedge clk) begin
        if (topo_rd_o) topo_data_i <= mem[topo_addr_o];
    end

    function automatic logic [REF_W-1:0] leaf(int a);
        return {1'b1, ADDR_W'(a)};
    endfunction

    function automatic logic [REF_W-1:0] node(int a);
        return {1'b0, ADDR_W'(a)};
    endfunction

    function automatic logic [ENTRY_W-1:0] ent(logic [REF_W-1:0] l, logic [REF_W-1:0] r,
                                               logic [REF_W-1:0] p);
        return {p, r, l};
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic void ref_walk(int r);
        int stk[$];
        int x;
        logic [ENTRY_W-1:0] e;
        exp_q.delete();
        stk.push_back(r);
        while (stk.size() > 0) begin
            x = stk.pop_back();
            exp_q.push_back(x);
            e = mem[x];
            if (!e[2*REF_W-1]) stk.push_back(int'(e[2*REF_W-2:REF_W]));
            if (!e[REF_W-1]) stk.push_back(int'(e[ADDR_W-1:0]));
        end
    endfunction

    task automatic run_walk(int r, bit inject, string req);
        int n;
        ref_walk(r);
        n = exp_q.size();
        @(negedge clk);
        start_i = 1'b1;
        root_i  = ADDR_W'(r);
        #1;
        chk(topo_rd_o && int'(topo_addr_o) == r, "R2 root read", int'(topo_addr_o), r);
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            #1;
            chk(ord_we_o === 1'b1, {req, " R4 write enable"}, int'(ord_we_o), 1);
            chk(int'(ord_addr_o) == i, {req, " R4 order address"}, int'(ord_addr_o), i);
            chk(int'(ord_data_o) == exp_q[i], {req, " node order"}, int'(ord_data_o), exp_q[i]);
            chk(busy_o === 1'b1, {req, " R11 busy during walk"}, int'(busy_o), 1);
            if (inject && i == 1) begin
                start_i = 1'b1;
                root_i  = '0;
            end
            @(negedge clk);
            start_i = 1'b0;
        end
        #1;
        chk(done_o === 1'b1, {req, " R9 done pulse"}, int'(done_o), 1);
        chk(busy_o === 1'b0, {req, " R9 idle at done"}, int'(busy_o), 0);
        chk(ord_we_o === 1'b0, {req, " R9 no write after end"}, int'(ord_we_o), 0);
        chk(int'(count_o) == n, {req, " R9 count"}, int'(count_o), n);
        @(negedge clk);
        #1;
        chk(done_o === 1'b0, {req, " R9 done single cycle"}, int'(done_o), 0);
        chk(int'(count_o) == n, {req, " R9 count held"}, int'(count_o), n);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(!busy_o && !done_o && !ord_we_o && !topo_rd_o, "R1 reset outputs", int'(busy_o), 0);
        chk(count_o == '0, "R1 reset count", int'(count_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!busy_o && !topo_rd_o, "R1 idle after reset", int'(busy_o), 0);

        // R5 R8: balanced tree, right branch saved then resumed
        mem[0] = ent(node(1), node(2), '1);
        mem[1] = ent(leaf(0), leaf(1), node(0));
        mem[2] = ent(leaf(2), leaf(3), node(0));
        run_walk(0, 1'b0, "R5");
        // R3: parent field altered, order must match
        mem[0] = ent(node(1), node(2), 6'b010101);
        mem[1] = ent(leaf(0), leaf(1), 6'b111000);
        mem[2] = ent(leaf(2), leaf(3), 6'b000111);
        run_walk(0, 1'b0, "R3");

        // R6: left comb
        mem[3] = ent(node(4), leaf(0), '1);
        mem[4] = ent(node(5), leaf(1), node(3));
        mem[5] = ent(leaf(2), leaf(3), node(4));
        run_walk(3, 1'b0, "R6");

        // R7: right comb
        mem[6] = ent(leaf(0), node(7), '1);
        mem[7] = ent(leaf(1), node(8), node(6));
        mem[8] = ent(leaf(2), leaf(3), node(7));
        run_walk(6, 1'b0, "R7");

        // R8: single node, empty stack at once
        mem[9] = ent(leaf(4), leaf(5), '1);
        run_walk(9, 1'b0, "R8");

        // R10: mixed subtree, second start injected mid-walk
        mem[10] = ent(node(11), node(12), node(0));
        mem[11] = ent(node(13), node(14), node(10));
        mem[12] = ent(node(15), leaf(6), node(10));
        mem[13] = ent(leaf(1), leaf(2), node(11));
        mem[14] = ent(leaf(3), leaf(4), node(11));
        mem[15] = ent(leaf(5), leaf(7), node(12));
        run_walk(10, 1'b1, "R10");

        // R11: complete tree with MAX_NODES internal nodes
        for (int i = 0; i < MAX_NODES; i++) begin
            if (2 * i + 2 < MAX_NODES)
                mem[i] = ent(node(2 * i + 1), node(2 * i + 2), '1);
            else
                mem[i] = ent(leaf(i), leaf(i + 1), '1);
        end
        run_walk(0, 1'b0, "R11");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule